// File: doc/BRIEF.md
# Single-Byte EEPROM I2C Master

This block accesses one byte of a serial I2C EEPROM at a time. It runs from one system clock. It drives SCL push-pull and controls SDA open-drain: the `sda_pull` output asks the pad to pull the line low, and `sda_in` returns the wired level. Two active-low push buttons start the accesses. One button writes a fixed data byte to a fixed word address. The other button reads that address back using the random-read framing: a dummy write carries the word address, then a repeated START opens a read.

The SCL period is four quarter-periods of `QTR_CYCLES` system clocks each. The default of 125 quarters a 50 MHz clock down to roughly 100 kHz. SDA changes in the first quarter, while SCL is low. The line is sampled at the end of the second quarter, which is the middle of the SCL high time. START and STOP move SDA in the third quarter, while SCL is held high. When a read completes, status outputs give the byte received and whether it equals the byte the write stores. If any acknowledge slot is missing its ACK, the block flags an error and ends the transaction with a STOP.

Top module: `eeprom_byte_master`

## Requirements
- R1: After reset the block is idle: `scl` is 1, `sda_pull` is 0, and `busy`, `ack_err` and `match` are all 0.
- R2: A press of `wr_btn_n` sends START, byte {DEV_ID,0}, word address, `WR_DATA`, then STOP. There is one START and one STOP, and each byte is followed by an acknowledge slot.
- R3: A press of `rd_btn_n` sends START, {DEV_ID,0}, word address, a repeated START, {DEV_ID,1}, then clocks in one byte and sends STOP. There are two STARTs and one STOP.
- R4: Every byte is sent and received most-significant bit first, so `rd_data` equals the byte the slave drove.
- R5: The master leaves SDA released (`sda_pull`=0) during the whole ninth clock of each byte it sends.
- R6: During the ninth clock after the read byte, the master leaves SDA high (NACK), then sends STOP.
- R7: If SDA is high in any acknowledge slot, `ack_err` is set, the master sends STOP without sending any further byte, and it returns to idle. The flag clears when the next transaction starts.
- R8: After a read without error, `match` is 1 exactly when `rd_data` equals `WR_DATA`. A transaction that ends in error clears `match`.
- R9: One press starts exactly one transaction, however long the button is held. Presses that arrive while `busy` is 1 are ignored.
- R10: While SCL is high, SDA changes only inside a START or a STOP.
- R11: Within a transaction, consecutive rising edges of SCL are 4*`QTR_CYCLES` system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_btn_n | input | 1 | Write button, active low, asynchronous |
| rd_btn_n | input | 1 | Read button, active low, asynchronous |
| scl | output | 1 | I2C clock |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| sda_in | input | 1 | Resolved SDA level |
| busy | output | 1 | Transaction in progress |
| ack_err | output | 1 | Last transaction saw a missing ACK |
| match | output | 1 | Last read byte equals the written byte |
| rd_data | output | 8 | Byte received by the last read |

## Verification
The hardest states to reach from the ports are a missing acknowledge in one particular slot, and a press that lands in the middle of a transaction. The bench models the EEPROM at the pin level. The model can refuse the acknowledge at any chosen byte index, and the bench sweeps that index over every acknowledge slot of both the write frame and the read frame. To cover the ignore cases, the bench presses the read button while a write is running and also holds a button down far beyond one transaction. It then counts the START conditions seen on the wire.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_START,
    SEG_TX,
    SEG_RX,
    SEG_STOP
  } seg_e;
endpackage

// File: rtl/eeprom_press.sv
module eeprom_press #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic press
);
  logic [STAGES-1:0] sync_q;
  logic              held_q;
  logic              level;

  assign level = ~sync_q[STAGES-1];
  assign press = level & ~held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      held_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], btn_n};
      held_q <= level;
    end
  end

  // R9
  single_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);
endmodule

// File: rtl/eeprom_qclk.sv
module eeprom_qclk #(
  parameter int QTR_CYCLES = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic [1:0] phase,
  output logic       qend
);
  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    ph_d;

  assign qend = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = phase;
    if (!run) begin
      cnt_d = '0;
      ph_d  = 2'd0;
    end else if (qend) begin
      cnt_d = '0;
      ph_d  = phase + 2'd1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 2'd0;
    end else begin
      cnt_q <= cnt_d;
      phase <= ph_d;
    end
  end

  // R11
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !qend) |=> $stable(phase));
endmodule

// File: rtl/eeprom_byte_master.sv
module eeprom_byte_master
  import eeprom_pkg::*;
#(
  parameter int          QTR_CYCLES  = 125,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ID      = 7'h50,
  parameter logic [7:0]  WORD_ADDR   = 8'h00,
  parameter logic [7:0]  WR_DATA     = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_btn_n,
  input  logic       rd_btn_n,
  output logic       scl,
  output logic       sda_pull,
  input  logic       sda_in,
  output logic       busy,
  output logic       ack_err,
  output logic       match,
  output logic [7:0] rd_data
);
  localparam int NBTN = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  // buttons: index 0 = write, 1 = read
  logic [NBTN-1:0] btn_vec, press;
  assign btn_vec = {rd_btn_n, wr_btn_n};
  for (genvar g = 0; g < NBTN; g++) begin : g_btn
    eeprom_press #(.STAGES(SYNC_STAGES)) i_press (
      .clk(clk), .rst_n(rst_s), .btn_n(btn_vec[g]), .press(press[g]));
  end

  logic [1:0] phase;
  logic       qend;
  eeprom_qclk #(.QTR_CYCLES(QTR_CYCLES)) i_qclk (
    .clk(clk), .rst_n(rst_s), .run(busy), .phase(phase), .qend(qend));

  // transaction programme: segment kind and byte per step
  function automatic seg_e plan_seg(input logic rd, input logic [2:0] st);
    if (!rd) begin
      case (st)
        3'd0:                plan_seg = SEG_START;
        3'd1, 3'd2, 3'd3:    plan_seg = SEG_TX;
        default:             plan_seg = SEG_STOP;
      endcase
    end else begin
      case (st)
        3'd0, 3'd3:          plan_seg = SEG_START;
        3'd1, 3'd2, 3'd4:    plan_seg = SEG_TX;
        3'd5:                plan_seg = SEG_RX;
        default:             plan_seg = SEG_STOP;
      endcase
    end
  endfunction

  function automatic logic [7:0] plan_byte(input logic rd, input logic [2:0] st);
    case (st)
      3'd1:    plan_byte = {DEV_ID, 1'b0};
      3'd2:    plan_byte = WORD_ADDR;
      3'd3:    plan_byte = WR_DATA;
      3'd4:    plan_byte = {DEV_ID, rd};
      default: plan_byte = 8'h00;
    endcase
  endfunction

  seg_e       seg_q, seg_d;
  logic [2:0] step_q, step_d, step_nx;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d, rdat_d;
  logic       rd_q, rd_d, nak_q, nak_d, err_d, match_d, adv;

  assign busy    = (seg_q != SEG_IDLE);
  assign step_nx = step_q + 3'd1;

  always_comb begin
    seg_d   = seg_q;
    step_d  = step_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    nak_d   = nak_q;
    err_d   = ack_err;
    match_d = match;
    rdat_d  = rd_data;
    adv     = 1'b0;
    if (seg_q == SEG_IDLE) begin
      if (press[0] || press[1]) begin
        rd_d   = !press[0];
        seg_d  = SEG_START;
        step_d = 3'd0;
        bit_d  = 4'd0;
        err_d  = 1'b0;
        nak_d  = 1'b0;
      end
    end else begin
      // sample point: end of quarter 1, middle of SCL high
      if (qend && phase == 2'd1) begin
        if (seg_q == SEG_TX && bit_q == 4'd8) nak_d = sda_in;
        if (seg_q == SEG_RX && bit_q < 4'd8)  sh_d  = {sh_q[6:0], sda_in};
      end
      // slot boundary
      if (qend && phase == 2'd3) begin
        case (seg_q)
          SEG_TX: begin
            if (bit_q < 4'd8) begin
              bit_d = bit_q + 4'd1;
              sh_d  = {sh_q[6:0], 1'b0};
            end else if (nak_q) begin
              err_d   = 1'b1;
              match_d = 1'b0;
              seg_d   = SEG_STOP;
            end else begin
              adv = 1'b1;
            end
          end
          SEG_RX: begin
            if (bit_q < 4'd8) begin
              bit_d = bit_q + 4'd1;
            end else begin
              rdat_d  = sh_q;
              match_d = (sh_q == WR_DATA);
              adv     = 1'b1;
            end
          end
          SEG_STOP: seg_d = SEG_IDLE;
          default:  adv = 1'b1;
        endcase
        if (adv) begin
          step_d = step_nx;
          seg_d  = plan_seg(rd_q, step_nx);
          bit_d  = 4'd0;
          if (plan_seg(rd_q, step_nx) == SEG_TX) sh_d = plan_byte(rd_q, step_nx);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      seg_q   <= SEG_IDLE;
      step_q  <= 3'd0;
      bit_q   <= 4'd0;
      sh_q    <= 8'h00;
      rd_q    <= 1'b0;
      nak_q   <= 1'b0;
      ack_err <= 1'b0;
      match   <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      seg_q   <= seg_d;
      step_q  <= step_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      nak_q   <= nak_d;
      ack_err <= err_d;
      match   <= match_d;
      rd_data <= rdat_d;
    end
  end

  // pin decode from registered state (quarters: 0 low, 1-2 high, 3 low)
  always_comb begin
    scl      = 1'b1;
    sda_pull = 1'b0;
    case (seg_q)
      SEG_START: begin
        scl      = phase[0] ^ phase[1];
        sda_pull = phase[1];
      end
      SEG_TX: begin
        scl      = phase[0] ^ phase[1];
        sda_pull = (bit_q < 4'd8) && !sh_q[7];
      end
      SEG_RX:   scl = phase[0] ^ phase[1];
      SEG_STOP: begin
        scl      = (phase != 2'd0);
        sda_pull = !phase[1];
      end
      default: ;
    endcase
  end

  // R10
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(busy) && busy && $past(scl) && scl && !$stable(sda_pull))
      |-> (seg_q == SEG_START || seg_q == SEG_STOP));

  // R7
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(ack_err) |-> (busy && seg_q == SEG_STOP));

  // R9
  idle_launch_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!busy && (press[0] || press[1])) |=> (seg_q == SEG_START && phase == 2'd0));

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && seg_q == SEG_TX && bit_q == 4'd8) |-> !sda_pull);
endmodule

// File: tb/test_eeprom_byte_master.sv
`timescale 1ns/1ps
module test_eeprom_byte_master;
  localparam int         QTR = 2;
  localparam logic [6:0] DID = 7'h50;
  localparam logic [7:0] WA  = 8'h3C;
  localparam logic [7:0] WD  = 8'hA5;

  logic clk, rst_n, wr_btn_n, rd_btn_n;
  logic scl, sda_pull, busy, ack_err, match;
  logic [7:0] rd_data;
  logic slave_pull;
  wire  sda_line = ~(sda_pull | slave_pull);

  eeprom_byte_master #(.QTR_CYCLES(QTR), .SYNC_STAGES(2), .DEV_ID(DID),
                       .WORD_ADDR(WA), .WR_DATA(WD)) i_eeprom_byte_master (
    .clk(clk), .rst_n(rst_n), .wr_btn_n(wr_btn_n), .rd_btn_n(rd_btn_n),
    .scl(scl), .sda_pull(sda_pull), .sda_in(sda_line), .busy(busy),
    .ack_err(ack_err), .match(match), .rd_data(rd_data));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- EEPROM pin model ----------------
  logic [7:0] mem [0:255];
  logic [7:0] logb [0:15];
  logic [7:0] sh, ptr, ctl;
  int mode, cnt, fidx, nlog, nack_at, starts, stops, contention;
  bit reading, nack, mack_high, p_scl, p_sda;

  always @(scl or sda_line) begin
    if (scl !== p_scl) begin
      if (scl) begin
        if (mode == 1) begin sh = {sh[6:0], sda_line}; cnt++; end
        else if (mode == 2) begin if (sda_pull) contention++; end
        else if (mode == 3) cnt++;
        else if (mode == 4) mack_high = sda_line;
      end else begin
        case (mode)
          1: if (cnt == 8) begin
               nack = (nlog == nack_at);
               if (nlog < 16) logb[nlog] = sh;
               nlog++;
               if (fidx == 0) begin
                 ctl = sh; reading = sh[0];
                 if (sh[7:1] != DID) nack = 1;
               end else if (fidx == 1) ptr = sh;
               else if (fidx == 2 && !ctl[0]) mem[ptr] = sh;
               fidx++;
               if (nack) begin mode = 0; slave_pull = 0; end
               else begin mode = 2; slave_pull = 1; end
             end
          2: begin
               slave_pull = 0; cnt = 0;
               if (reading) begin mode = 3; slave_pull = ~mem[ptr][7]; end
               else mode = 1;
             end
          3: if (cnt == 8) begin slave_pull = 0; mode = 4; end
             else slave_pull = ~mem[ptr][7-cnt];
          4: mode = 0;
          default: ;
        endcase
      end
    end else if (scl && (sda_line !== p_sda)) begin
      if (!sda_line) begin starts++; mode = 1; cnt = 0; fidx = 0; reading = 0; slave_pull = 0; end
      else begin stops++; mode = 0; slave_pull = 0; end
    end
    p_scl = scl;
    p_sda = sda_line;
  end

  // R11 SCL rise-to-rise spacing monitor
  int since = 0, per_n = 0, per_bad = 0;
  bit have = 0, scl_prev = 1;
  always @(negedge clk) begin
    if (busy) begin
      since++;
      if (scl && !scl_prev) begin
        if (have) begin per_n++; if (since != 4*QTR) per_bad++; end
        have = 1; since = 0;
      end
    end else begin
      have = 0; since = 0;
    end
    scl_prev = scl;
  end

  task automatic clear_log();
    nlog = 0; starts = 0; stops = 0; mack_high = 0; contention = 0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (!busy && t < 50) begin @(negedge clk); t++; end
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
  endtask

  task automatic run_op(input bit rd);
    @(negedge clk);
    if (rd) rd_btn_n = 0; else wr_btn_n = 0;
    repeat (4) @(negedge clk);
    wr_btn_n = 1; rd_btn_n = 1;
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    slave_pull = 0; mode = 0; cnt = 0; fidx = 0; nack_at = -1;
    p_scl = 1; p_sda = 1; reading = 0; nack = 0;
    sh = 0; ptr = 0; ctl = 0;
    clear_log();
    wr_btn_n = 1; rd_btn_n = 1; rst_n = 0;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);

    // R1 idle after reset
    chk("R1 scl", scl, 1);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ack_err", ack_err, 0);
    chk("R1 match", match, 0);

    // R2 write frame
    clear_log();
    run_op(0);
    chk("R2 bytes", nlog, 3);
    chk("R2 ctl", logb[0], {DID, 1'b0});
    chk("R2 addr", logb[1], WA);
    chk("R2 data", logb[2], WD);
    chk("R2/R10 starts", starts, 1);
    chk("R2 stops", stops, 1);
    chk("R2 stored", mem[WA], WD);
    chk("R7 no error", ack_err, 0);
    chk("R5 no contention", contention, 0);

    // R3 read frame
    clear_log();
    run_op(1);
    chk("R3 bytes", nlog, 3);
    chk("R3 ctl w", logb[0], {DID, 1'b0});
    chk("R3 addr", logb[1], WA);
    chk("R3 ctl r", logb[2], {DID, 1'b1});
    chk("R3/R10 starts", starts, 2);
    chk("R3 stops", stops, 1);
    chk("R4 rd_data", rd_data, WD);
    chk("R8 match", match, 1);
    chk("R6 master nack", mack_high, 1);
    chk("R5 no contention", contention, 0);
    chk("R11 period", per_bad, 0);

    // R4/R8 sweep of stored values
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11);
      if (i == 7) v = WD;
      mem[WA] = v;
      clear_log();
      run_op(1);
      chk("R4 sweep rd_data", rd_data, v);
      chk("R8 sweep match", match, (v == WD) ? 1 : 0);
      chk("R6 sweep nack", mack_high, 1);
    end
    mem[WA] = WD;

    // R7 missing ACK in each write slot
    for (int k = 0; k < 3; k++) begin
      clear_log(); nack_at = k;
      run_op(0);
      nack_at = -1;
      chk("R7 wr err", ack_err, 1);
      chk("R7 wr bytes", nlog, k + 1);
      chk("R7 wr stop", stops, 1);
      chk("R7 wr idle", busy, 0);
      chk("R7 wr scl", scl, 1);
    end
    clear_log(); run_op(0);
    chk("R7 clears", ack_err, 0);

    // R7/R8 missing ACK in each read slot
    for (int k = 0; k < 3; k++) begin
      clear_log(); run_op(1);
      chk("R8 pre match", match, 1);
      clear_log(); nack_at = k;
      run_op(1);
      nack_at = -1;
      chk("R7 rd err", ack_err, 1);
      chk("R7 rd bytes", nlog, k + 1);
      chk("R7 rd stop", stops, 1);
      chk("R8 err clears match", match, 0);
    end

    // R9 held button: one transaction
    clear_log();
    @(negedge clk); wr_btn_n = 0;
    wait_idle();
    repeat (300) @(negedge clk);
    chk("R9 held busy", busy, 0);
    wr_btn_n = 1;
    repeat (50) @(negedge clk);
    chk("R9 held starts", starts, 1);

    // R9 press while busy ignored
    clear_log();
    @(negedge clk); wr_btn_n = 0;
    repeat (4) @(negedge clk); wr_btn_n = 1;
    while (!busy) @(negedge clk);
    repeat (20) @(negedge clk);
    rd_btn_n = 0; repeat (4) @(negedge clk); rd_btn_n = 1;
    wait_idle();
    repeat (200) @(negedge clk);
    chk("R9 busy press starts", starts, 1);
    chk("R9 busy press frame", logb[0], {DID, 1'b0});
    chk("R9 busy press idle", busy, 0);

    chk("R11 period all", per_bad, 0);
    chk("R11 measured", (per_n > 100) ? 1 : 0, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule